// File: doc/BRIEF.md
# Supply Supervisor with Reset Hold and Bus-Kicked Watchdog

This block is the digital half of a processor supply supervisor. Two comparators outside the block report that the main supply or a secondary supply is under its trip point. Both flags arrive already synchronized to the block clock. The block drives three outputs from them: a processor reset, a watchdog overflow flag and a secondary-supply fail flag. Reset is held on while the main supply is low. It stays on for a programmable hold time once the supply has recovered, so that the supply and the oscillator can settle before code runs.

The watchdog is restarted by START conditions on a two-wire serial bus. The block watches the bus clock and data lines and reacts to data falling while the clock is high, so the processor has no separate kick pin to drive. Two select bits choose the reset hold time. Two more choose the watchdog period or switch the watchdog off. Every interval is measured in pulses of a millisecond tick input, which is prescaled outside the block.

Top module: `supervisor_ctrl`

## Requirements
- R1: While `rst_n` is low, `rst_out` is 1, `wd_ovf` is 0 and `sec_fail` is 0. Once `rst_n` is released, the block behaves as if the main supply has just recovered and runs the full hold time.
- R2: Whenever `vmain_low` is 1, `rst_out` is 1 from the next clock edge onward, whatever the state of any other input.
- R3: Once `vmain_low` returns to 0, `rst_out` stays 1 for a hold time set by `pup_sel`, accurate to within one tick: 2'b00 gives 50 ticks, 2'b01 gives 200, 2'b10 gives 400 and 2'b11 gives 800.
- R4: If `vmain_low` rises again before the hold time has run out, the hold count starts over, and the full hold time is measured from the last time `vmain_low` fell.
- R5: The watchdog overflows this many ticks (within one) after the last START condition: 1400 ticks when `wd_sel` is 2'b00, 200 ticks for 2'b01 and 25 ticks for 2'b10. On overflow, `wd_ovf` goes to 1.
- R6: When `wd_sel` is 2'b11 the watchdog is off: its count is held at zero and `wd_ovf` stays 0 however long the bus stays quiet.
- R7: A START condition is `sda` changing from 1 to 0 while `scl` is 1 in both cycles. A START restarts the watchdog count and clears `wd_ovf`. With no START, `wd_ovf` stays 1 once it is set.
- R8: If `sda` falls while `scl` is 0, that is not a START. It neither restarts the watchdog nor clears `wd_ovf`.
- R9: While `rst_out` is 1, the watchdog count is held at zero and `wd_ovf` is 0. Once reset is released, the watchdog period starts from zero.
- R10: `sec_fail` follows `vsec_low` one clock later, in both directions. Reset and the watchdog have no effect on it.
- R11: The hold count and the watchdog count move forward only on cycles where `tick_ms` is 1. Without ticks, `rst_out` and `wd_ovf` do not change on their own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle timing tick, nominally every millisecond |
| vmain_low | input | 1 | Main supply below its trip point (synchronized) |
| vsec_low | input | 1 | Secondary supply below its trip point (synchronized) |
| scl | input | 1 | Two-wire bus clock line (synchronized) |
| sda | input | 1 | Two-wire bus data line (synchronized) |
| pup_sel | input | 2 | Reset hold time select |
| wd_sel | input | 2 | Watchdog period select, 2'b11 turns the watchdog off |
| rst_out | output | 1 | Processor reset, active high |
| wd_ovf | output | 1 | Watchdog overflow flag, active high |
| sec_fail | output | 1 | Secondary supply fail flag, active high |

## Verification
The hardest case to reach from the ports is the interaction between reset and the watchdog. The stimulus lets the watchdog overflow, then drops the main supply for longer than a whole watchdog period. The bench checks that the overflow clears, that nothing counts during the hold, and that the next overflow comes one hold time plus one watchdog period after the supply recovers. The bench also shapes the bus lines on purpose, so that data falls while the bus clock is low, and checks that this does not shift the overflow time. Finally, it gates the tick off for longer than the shortest hold time to show that time is measured in ticks, not in clock cycles.

// File: rtl/sup_pkg.sv
// Package: shared select encodings and a small helper for the supervisor.
// Assumes: nothing; holds types and pure functions only.
package sup_pkg;

    // Watchdog period select encoding.
    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

    // Larger of two integers, used to size shared counters.
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sup_start_det.sv
// Module: sup_start_det
// Spots a START on the two-wire bus: data falls while the clock stays high.
// Assumes: scl and sda are already synchronized to clk. The pulse is
// combinational from the current and previous samples, so a START is acted
// on at the first edge that sees data low.
module sup_start_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start_p
);
    logic scl_q;
    logic sda_q;

    // Keep the previous sample of both bus lines; the idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Clock high in both samples while data goes from high to low.
    always_comb begin
        start_p = scl_q & scl & sda_q & ~sda;
    end
endmodule

// File: rtl/sup_por_hold.sv
// Module: sup_por_hold
// Holds reset while the main supply is low. After the supply recovers it
// keeps reset on for one of four tick counts chosen by sel.
// Assumes: main_low is synchronized and tick is a one-cycle pulse. The select
// is read on every tick, so a change takes effect at once.
module sup_por_hold #(
    parameter int T00 = 50,
    parameter int T01 = 200,
    parameter int T10 = 400,
    parameter int T11 = 800,
    parameter int W   = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       main_low,
    input  logic [1:0] sel,
    output logic       rst_active
);
    localparam logic [W-1:0] L00 = W'(T00);
    localparam logic [W-1:0] L01 = W'(T01);
    localparam logic [W-1:0] L10 = W'(T10);
    localparam logic [W-1:0] L11 = W'(T11);

    logic [W-1:0] cnt;
    logic [W-1:0] limit;
    logic         done;

    // Pick the hold length for the current select value.
    always_comb begin
        unique case (sel)
            2'b00:   limit = L00;
            2'b01:   limit = L01;
            2'b10:   limit = L10;
            default: limit = L11;
        endcase
    end

    // The hold ends on the tick that would bring the count to the limit.
    always_comb begin
        done = ((cnt + W'(1)) >= limit);
    end

    // Reset flag and hold counter; a low supply starts the hold over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_active <= 1'b1;
            cnt        <= '0;
        end else if (main_low) begin
            rst_active <= 1'b1;
            cnt        <= '0;
        end else if (rst_active && tick) begin
            if (done) begin
                rst_active <= 1'b0;
                cnt        <= '0;
            end else begin
                cnt <= cnt + W'(1);
            end
        end
    end
endmodule

// File: rtl/sup_wdog.sv
// Module: sup_wdog
// Watchdog timer with three periods and an off setting. A START restarts it.
// The overflow flag is sticky until the next START.
// Assumes: hold is the processor reset, which keeps the timer cleared, and
// tick is a one-cycle pulse.
module sup_wdog
    import sup_pkg::*;
#(
    parameter int P_LONG  = 1400,
    parameter int P_MID   = 200,
    parameter int P_SHORT = 25,
    parameter int W       = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hold,
    input  logic       kick,
    input  logic [1:0] sel,
    output logic       ovf
);
    localparam logic [W-1:0] LL = W'(P_LONG);
    localparam logic [W-1:0] LM = W'(P_MID);
    localparam logic [W-1:0] LS = W'(P_SHORT);

    wd_sel_e      mode;
    logic [W-1:0] cnt;
    logic [W-1:0] period;
    logic         off;

    // Decode the select into a period and an off flag.
    always_comb begin
        mode   = wd_sel_e'(sel);
        off    = (mode == WD_OFF);
        unique case (mode)
            WD_LONG:  period = LL;
            WD_MID:   period = LM;
            WD_SHORT: period = LS;
            default:  period = LL;
        endcase
    end

    // Count, in priority order: clear, restart, count on tick, then flag.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || off) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (kick) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (tick && !ovf) begin
            if ((cnt + W'(1)) >= period) begin
                ovf <= 1'b1;
                cnt <= '0;
            end else begin
                cnt <= cnt + W'(1);
            end
        end
    end
endmodule

// File: rtl/supervisor_ctrl.sv
// Module: supervisor_ctrl (top)
// Supply supervisor: reset hold after main supply recovery, a bus-kicked
// watchdog and a registered secondary-supply fail flag.
// Assumes: all single-bit inputs are synchronized to clk, and tick_ms is a
// one-cycle pulse per millisecond.
module supervisor_ctrl #(
    parameter int POR_T00 = 50,
    parameter int POR_T01 = 200,
    parameter int POR_T10 = 400,
    parameter int POR_T11 = 800,
    parameter int WD_T00  = 1400,
    parameter int WD_T01  = 200,
    parameter int WD_T10  = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       vmain_low,
    input  logic       vsec_low,
    input  logic       scl,
    input  logic       sda,
    input  logic [1:0] pup_sel,
    input  logic [1:0] wd_sel,
    output logic       rst_out,
    output logic       wd_ovf,
    output logic       sec_fail
);
    localparam int MAX_T = sup_pkg::max_int(
        sup_pkg::max_int(sup_pkg::max_int(POR_T00, POR_T01),
                         sup_pkg::max_int(POR_T10, POR_T11)),
        sup_pkg::max_int(sup_pkg::max_int(WD_T00, WD_T01), WD_T10));
    localparam int CNT_W = $clog2(MAX_T + 1);

    logic start_p;

    sup_start_det u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (scl),
        .sda     (sda),
        .start_p (start_p)
    );

    sup_por_hold #(
        .T00 (POR_T00),
        .T01 (POR_T01),
        .T10 (POR_T10),
        .T11 (POR_T11),
        .W   (CNT_W)
    ) u_por (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_ms),
        .main_low   (vmain_low),
        .sel        (pup_sel),
        .rst_active (rst_out)
    );

    sup_wdog #(
        .P_LONG  (WD_T00),
        .P_MID   (WD_T01),
        .P_SHORT (WD_T10),
        .W       (CNT_W)
    ) u_wd (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_ms),
        .hold  (rst_out),
        .kick  (start_p),
        .sel   (wd_sel),
        .ovf   (wd_ovf)
    );

    // Register the secondary comparator flag onto the fail output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_fail <= 1'b0;
        end else begin
            sec_fail <= vsec_low;
        end
    end
endmodule

// File: rtl/sup_checker.sv
// Module: sup_checker
// Port-level properties of supervisor_ctrl, attached with bind.
// Assumes: the same clock and synchronous reset as the design.
module sup_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_ms,
    input logic       vmain_low,
    input logic       vsec_low,
    input logic       scl,
    input logic       sda,
    input logic [1:0] wd_sel,
    input logic       rst_out,
    input logic       wd_ovf,
    input logic       sec_fail
);
    logic scl_m;
    logic sda_m;
    logic start_m;

    // Independent copy of the bus samples, used to spot a START.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            sda_m <= 1'b1;
        end else begin
            scl_m <= scl;
            sda_m <= sda;
        end
    end

    always_comb start_m = scl_m & scl & sda_m & ~sda;

    p_rst_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vmain_low |=> rst_out);

    p_wd_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_sel == 2'b11) |=> !wd_ovf);

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_ovf && !start_m && !rst_out && wd_sel != 2'b11) |=> wd_ovf);

    p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_m |=> !wd_ovf);

    p_no_ovf_in_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |=> !wd_ovf);

    p_sec_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vsec_low |=> sec_fail);

    p_sec_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vsec_low |=> !sec_fail);

    p_ovf_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_ovf) |-> $past(tick_ms));

    p_rst_drop_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> $past(tick_ms));
endmodule

bind supervisor_ctrl sup_checker u_sup_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_ms   (tick_ms),
    .vmain_low (vmain_low),
    .vsec_low  (vsec_low),
    .scl       (scl),
    .sda       (sda),
    .wd_sel    (wd_sel),
    .rst_out   (rst_out),
    .wd_ovf    (wd_ovf),
    .sec_fail  (sec_fail)
);

// File: tb/tb_supervisor_ctrl.sv
// Bench for supervisor_ctrl: a table-driven sweep of hold times and watchdog
// periods, then directed tests for reset, the bus and the tick.
module tb_supervisor_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_ms;
    logic       vmain_low;
    logic       vsec_low;
    logic       scl;
    logic       sda;
    logic [1:0] pup_sel;
    logic [1:0] wd_sel;
    logic       rst_out;
    logic       wd_ovf;
    logic       sec_fail;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam int POR_EXP [4] = '{50, 200, 400, 800};
    localparam int WD_EXP  [3] = '{1400, 200, 25};

    always #10 clk = ~clk;

    supervisor_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_ms   (tick_ms),
        .vmain_low (vmain_low),
        .vsec_low  (vsec_low),
        .scl       (scl),
        .sda       (sda),
        .pup_sel   (pup_sel),
        .wd_sel    (wd_sel),
        .rst_out   (rst_out),
        .wd_ovf    (wd_ovf),
        .sec_fail  (sec_fail)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count negedges until rst_out reads 0.
    task automatic time_rst(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rst_out && n < 3000);
    endtask

    // Count negedges until wd_ovf reads 1.
    task automatic time_ovf(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!wd_ovf && n < 3000);
    endtask

    // Main supply dip; returns at a negedge with vmain_low just cleared.
    task automatic dip(input int len);
        vmain_low = 1'b1;
        wait_cyc(len);
        vmain_low = 1'b0;
    endtask

    // START: sda falls with scl high; returns one edge later with sda high.
    task automatic start_cond();
        sda = 1'b0;
        @(negedge clk);
        sda = 1'b1;
    endtask

    function automatic bit near(input int a, input int b);
        return (a >= b - 1) && (a <= b + 1);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        int n;
        rst_n = 1'b0; tick_ms = 1'b1; vmain_low = 1'b0; vsec_low = 1'b0;
        scl = 1'b1; sda = 1'b1; pup_sel = 2'b01; wd_sel = 2'b11;
        wait_cyc(4);
        // R1: values held during reset
        chk(rst_out == 1'b1, "R1 rst_out in reset", int'(rst_out), 1);
        chk(wd_ovf == 1'b0, "R1 wd_ovf in reset", int'(wd_ovf), 0);
        chk(sec_fail == 1'b0, "R1 sec_fail in reset", int'(sec_fail), 0);
        rst_n = 1'b1;
        time_rst(n);
        chk(near(n, 200), "R1 default hold after rst_n", n, 200);

        // R3: table of hold times per select
        for (int i = 0; i < 4; i++) begin
            pup_sel = 2'(i);
            vmain_low = 1'b1;
            wait_cyc(3);
            chk(rst_out == 1'b1, "R2 reset while main low", int'(rst_out), 1);
            vmain_low = 1'b0;
            time_rst(n);
            chk(near(n, POR_EXP[i]), "R3 hold time", n, POR_EXP[i]);
        end

        // R5: table of watchdog periods per select
        pup_sel = 2'b00;
        for (int i = 0; i < 3; i++) begin
            wd_sel = 2'(i);
            start_cond();
            time_ovf(n);
            chk(near(n, WD_EXP[i]), "R5 watchdog period", n, WD_EXP[i]);
        end

        // R7: sticky overflow, cleared by START
        wait_cyc(100);
        chk(wd_ovf == 1'b1, "R7 overflow stays set", int'(wd_ovf), 1);
        start_cond();
        chk(wd_ovf == 1'b0, "R7 START clears overflow", int'(wd_ovf), 0);

        // R8: data falling with clock low is not a START
        wd_sel = 2'b10;
        start_cond();
        wait_cyc(15);
        scl = 1'b0; @(negedge clk);
        sda = 1'b0; @(negedge clk);
        sda = 1'b1; @(negedge clk);
        scl = 1'b1;
        time_ovf(n);
        chk(near(n + 18, 25), "R8 fake start ignored", n + 18, 25);

        // R2 with a bus active: main low forces reset
        vmain_low = 1'b1;
        wait_cyc(2);
        chk(rst_out == 1'b1, "R2 reset asserted", int'(rst_out), 1);
        // R9: overflow cleared and watchdog frozen during reset
        chk(wd_ovf == 1'b0, "R9 overflow cleared by reset", int'(wd_ovf), 0);
        wait_cyc(40);
        chk(wd_ovf == 1'b0, "R9 no count during reset", int'(wd_ovf), 0);
        vmain_low = 1'b0;
        time_rst(n);
        chk(near(n, 50), "R9 hold before watchdog", n, 50);
        chk(wd_ovf == 1'b0, "R9 watchdog restarts from zero", int'(wd_ovf), 0);
        time_ovf(n);
        chk(near(n, 25), "R9 period after reset", n, 25);

        // R4: dip during hold restarts the hold
        dip(3);
        wait_cyc(30);
        dip(1);
        time_rst(n);
        chk(near(n, 50), "R4 hold restarted", n, 50);

        // R6: disabled watchdog never overflows
        wd_sel = 2'b11;
        wait_cyc(2);
        chk(wd_ovf == 1'b0, "R6 off clears overflow", int'(wd_ovf), 0);
        wait_cyc(1500);
        chk(wd_ovf == 1'b0, "R6 off stays quiet", int'(wd_ovf), 0);

        // R10: secondary flag follows with one clock delay
        vsec_low = 1'b1;
        @(negedge clk);
        chk(sec_fail == 1'b1, "R10 sec_fail set", int'(sec_fail), 1);
        vmain_low = 1'b1;
        wait_cyc(3);
        chk(sec_fail == 1'b1, "R10 sec_fail unaffected by reset", int'(sec_fail), 1);
        vmain_low = 1'b0;
        vsec_low = 1'b0;
        @(negedge clk);
        chk(sec_fail == 1'b0, "R10 sec_fail clears", int'(sec_fail), 0);

        // R11: no ticks, no progress
        tick_ms = 1'b0;
        dip(3);
        wait_cyc(200);
        chk(rst_out == 1'b1, "R11 hold frozen without tick", int'(rst_out), 1);
        tick_ms = 1'b1;
        time_rst(n);
        chk(near(n, 50), "R11 hold resumes with tick", n, 50);
        wd_sel = 2'b10;
        start_cond();
        tick_ms = 1'b0;
        wait_cyc(100);
        chk(wd_ovf == 1'b0, "R11 watchdog frozen without tick", int'(wd_ovf), 0);
        tick_ms = 1'b1;
        time_ovf(n);
        chk(near(n, 25), "R11 watchdog resumes with tick", n, 25);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule